// File: doc/BRIEF.md
# Clock Distribution Divider with Reference Bypass

This block is the digital back end of a zero-delay clock buffer. It runs on a fast oscillator clock and turns it into a set of related distribution clocks: a double-rate clock, a bank of in-phase Q clocks, one inverted Q clock and a half-rate clock. Each of these outputs has its own level signal and its own output-enable, so the pad ring can build the tri-state drivers. A frequency-select input puts a divide-by-1 or divide-by-2 stage in front of the divider chain. A reference-select input picks one of two reference clocks. That reference goes out to the phase comparator, and it is also the test-mode clock.

With the loop enable low, the block runs in bypass test mode. The oscillator path is ignored and the selected reference, synchronised to the fast clock over two stages, drives the divider chain directly. The double-rate clock is the inverse of the reference, and the Q clocks advance on every falling reference edge. The active-low enable/reset input does two things. It removes every output-enable at once, and on each clock edge it clears the divider flops. While it is held low, the double-rate level follows the inverse of the synchronised reference. After release in bypass mode the Q, inverted Q and half-rate outputs stay low until the first falling reference edge arrives.

All output transitions are produced by flops on the same fast clock edge. Because of this, the rising edges of the double-rate, Q and half-rate clocks always coincide.

Top module: `clkdist_top`

## Requirements
- R1: `ref_cmp_o` equals `ref_b` when `ref_pick` is 1 and `ref_a` when it is 0; the unselected reference has no effect on any output.
- R2: All NUM_Q (default 5) Q outputs carry the same value in every cycle.
- R3: With `loop_en`=1 and `div_one`=1, over the first 64 clocks after release the double-rate output rises 32 times, Q rises 16 times and the half-rate output rises 8 times.
- R4: With `loop_en`=1 and `div_one`=0, over the first 64 clocks after release the double-rate output rises 16 times, Q rises 8 times and the half-rate output rises 4 times.
- R5: The half-rate output rises only in a cycle where Q rises, and Q changes only in a cycle where the double-rate output rises.
- R6: Every output-enable is low while `oe_rst_n` is low and high while it is high, with no clock delay.
- R7: A clock edge with `oe_rst_n` low clears Q, the inverted Q and the half-rate output to 0. The inverted Q stays 0 until the first Q toggle after release and is the complement of Q after that.
- R8: While `oe_rst_n` is low, the double-rate output is the inverse of the selected reference as it was three clocks earlier. In bypass mode the Q outputs stay 0 after release until the first falling edge of the selected reference.
- R9: With `loop_en`=0, the double-rate output is the inverse of the selected reference delayed by three clocks, Q toggles at each falling reference edge (three clocks of latency), and the half-rate output toggles at every second such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Fast oscillator clock |
| oe_rst_n | input | 1 | Active-low output enable and divider clear |
| loop_en | input | 1 | 1: oscillator drives dividers; 0: reference bypass test mode |
| div_one | input | 1 | 1: divide oscillator by 1; 0: divide by 2 |
| ref_pick | input | 1 | Reference select, 1 picks ref_b |
| ref_a | input | 1 | Reference clock 0 |
| ref_b | input | 1 | Reference clock 1 |
| ref_cmp_o | output | 1 | Selected reference toward the phase comparator |
| q_o | output | NUM_Q | In-phase Q clock levels |
| q_oe_o | output | NUM_Q | Output-enables for q_o |
| qn_o | output | 1 | Inverted Q clock level |
| qn_oe_o | output | 1 | Output-enable for qn_o |
| dbl_o | output | 1 | Double-rate clock level |
| dbl_oe_o | output | 1 | Output-enable for dbl_o |
| half_o | output | 1 | Half-rate clock level |
| half_oe_o | output | 1 | Output-enable for half_o |

## Verification
The divider chain is run in three modes. A constant reference combined with each of the two divide settings separates the divide-by-1 rates from the divide-by-2 rates. A bypass run uses a reference with a regular 3-low/3-high pattern, and a second bypass run uses a faster reference on the other select input; these show that Q follows falling reference edges and not the oscillator. Throughout, the unselected reference toggles every clock, so any leak through the multiplexer would show up. Mode changes made both with and without a hold between them, together with a long constant reference after release, test the hold-low behaviour and the inverted-Q start-up.

// File: rtl/clkdist_pkg.sv
`timescale 1ns/1ps
package clkdist_pkg;

    localparam int unsigned NUM_Q_DEF       = 5;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        MODE_HOLD      = 2'd0,
        MODE_BYPASS    = 2'd1,
        MODE_LOOP_DIV1 = 2'd2,
        MODE_LOOP_DIV2 = 2'd3
    } dist_mode_e;

    typedef struct packed {
        logic dbl;
        logic dbl_rise;
    } fast_lvl_t;

    function automatic logic ref_pick_fn(input logic pick, input logic a, input logic b);
        return pick ? b : a;
    endfunction

    function automatic dist_mode_e mode_decode(input logic hold, input logic loop_en,
                                               input logic div_one);
        if (hold)         return MODE_HOLD;
        else if (!loop_en) return MODE_BYPASS;
        else if (div_one) return MODE_LOOP_DIV1;
        else              return MODE_LOOP_DIV2;
    endfunction

endpackage

// File: rtl/clkdist_ref_path.sv
`timescale 1ns/1ps
module clkdist_ref_path
    import clkdist_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk_i,
    input  logic ref_pick_i,
    input  logic ref_a_i,
    input  logic ref_b_i,
    output logic ref_sel_o,
    output logic ref_now_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_r;

    assign ref_sel_o = ref_pick_fn(ref_pick_i, ref_a_i, ref_b_i);

    always_ff @(posedge clk_i) begin
        sync_r <= {sync_r[SYNC_STAGES-2:0], ref_sel_o};
    end

    assign ref_now_o = sync_r[LAST];

endmodule

// File: rtl/clkdist_fast_stage.sv
`timescale 1ns/1ps
module clkdist_fast_stage
    import clkdist_pkg::*;
(
    input  logic       clk_i,
    input  dist_mode_e mode_i,
    input  logic       ref_now_i,
    output fast_lvl_t  fast_o
);
    logic dbl_r, pre_r;
    logic dbl_nxt, pre_nxt, tick;

    always_comb begin
        tick    = 1'b0;
        pre_nxt = 1'b0;
        dbl_nxt = dbl_r;
        unique case (mode_i)
            MODE_HOLD:      dbl_nxt = ~ref_now_i;
            MODE_BYPASS:    dbl_nxt = ~ref_now_i;
            MODE_LOOP_DIV1: begin
                tick    = 1'b1;
                dbl_nxt = ~dbl_r;
            end
            MODE_LOOP_DIV2: begin
                tick    = pre_r;
                pre_nxt = ~pre_r;
                dbl_nxt = pre_r ? ~dbl_r : dbl_r;
            end
            default: dbl_nxt = dbl_r;
        endcase
    end

    always_ff @(posedge clk_i) begin
        dbl_r <= dbl_nxt;
        pre_r <= pre_nxt;
    end

    assign fast_o.dbl      = dbl_r;
    assign fast_o.dbl_rise = (mode_i != MODE_HOLD) & dbl_nxt & ~dbl_r;

    // R4: with divide-by-2, fast ticks never come on two consecutive edges
    p_div2_spacing_r4: assert property (@(posedge clk_i) disable iff (mode_i == MODE_HOLD)
        (mode_i == MODE_LOOP_DIV2 && tick) |=> (mode_i != MODE_LOOP_DIV2 || !tick));

    // R3: with divide-by-1 the double-rate level changes on every edge
    p_div1_toggle_r3: assert property (@(posedge clk_i) disable iff (mode_i == MODE_HOLD)
        ($past(mode_i) == MODE_LOOP_DIV1) |-> (dbl_r != $past(dbl_r)));

endmodule

// File: rtl/clkdist_div_chain.sv
`timescale 1ns/1ps
module clkdist_div_chain
    import clkdist_pkg::*;
#(
    parameter int unsigned NUM_Q = NUM_Q_DEF
) (
    input  logic             clk_i,
    input  logic             hold_i,
    input  logic             dbl_rise_i,
    output logic [NUM_Q-1:0] q_o,
    output logic             qn_o,
    output logic             half_o
);
    logic qn_r, half_r;
    logic seen_r = 1'b0;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_lane
        logic lane_r;
        always_ff @(posedge clk_i) begin
            if (hold_i)          lane_r <= 1'b0;
            else if (dbl_rise_i) lane_r <= ~lane_r;
        end
        assign q_o[g] = lane_r;
    end

    always_ff @(posedge clk_i) begin
        if (hold_i) begin
            qn_r   <= 1'b0;
            half_r <= 1'b0;
        end else if (dbl_rise_i) begin
            qn_r <= q_o[0];
            if (!q_o[0]) half_r <= ~half_r;
        end
    end

    always_ff @(posedge clk_i) begin
        seen_r <= seen_r | hold_i;
    end

    assign qn_o   = qn_r;
    assign half_o = half_r;

    // R2: all lanes carry one phase
    p_q_in_phase_r2: assert property (@(posedge clk_i) disable iff (hold_i)
        (q_o == '0) || (q_o == '1));

    // R5: half-rate rises only together with a Q rise
    p_half_on_q_rise_r5: assert property (@(posedge clk_i) disable iff (hold_i)
        $rose(half_r) |-> $rose(q_o[0]));

    // R7: inverted Q is never high together with Q
    p_qn_compl_r7: assert property (@(posedge clk_i) disable iff (hold_i)
        q_o[0] |-> !qn_r);

    // R7: an edge under hold leaves the chain cleared
    p_held_low_r7: assert property (@(posedge clk_i) disable iff (!seen_r)
        $past(hold_i) |-> (q_o == '0 && !qn_r && !half_r));

endmodule

// File: rtl/clkdist_top.sv
`timescale 1ns/1ps
module clkdist_top
    import clkdist_pkg::*;
#(
    parameter int unsigned NUM_Q       = NUM_Q_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk_osc,
    input  logic             oe_rst_n,
    input  logic             loop_en,
    input  logic             div_one,
    input  logic             ref_pick,
    input  logic             ref_a,
    input  logic             ref_b,
    output logic             ref_cmp_o,
    output logic [NUM_Q-1:0] q_o,
    output logic [NUM_Q-1:0] q_oe_o,
    output logic             qn_o,
    output logic             qn_oe_o,
    output logic             dbl_o,
    output logic             dbl_oe_o,
    output logic             half_o,
    output logic             half_oe_o
);
    localparam int unsigned ARM_W = 3;

    logic       hold;
    dist_mode_e mode;
    logic       ref_now;
    fast_lvl_t  fast;
    logic [ARM_W-1:0] arm_cnt;
    logic             arm_done;

    assign hold = ~oe_rst_n;
    assign mode = mode_decode(hold, loop_en, div_one);

    clkdist_ref_path #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk_i      (clk_osc),
        .ref_pick_i (ref_pick),
        .ref_a_i    (ref_a),
        .ref_b_i    (ref_b),
        .ref_sel_o  (ref_cmp_o),
        .ref_now_o  (ref_now)
    );

    clkdist_fast_stage u_fast (
        .clk_i     (clk_osc),
        .mode_i    (mode),
        .ref_now_i (ref_now),
        .fast_o    (fast)
    );

    clkdist_div_chain #(.NUM_Q(NUM_Q)) u_chain (
        .clk_i      (clk_osc),
        .hold_i     (hold),
        .dbl_rise_i (fast.dbl_rise),
        .q_o        (q_o),
        .qn_o       (qn_o),
        .half_o     (half_o)
    );

    assign dbl_o     = fast.dbl;
    assign q_oe_o    = {NUM_Q{oe_rst_n}};
    assign qn_oe_o   = oe_rst_n;
    assign dbl_oe_o  = oe_rst_n;
    assign half_oe_o = oe_rst_n;

    always_ff @(posedge clk_osc) begin
        if (hold)           arm_cnt <= '0;
        else if (!arm_done) arm_cnt <= arm_cnt + 1'b1;
    end
    assign arm_done = (arm_cnt == ARM_W'(4));

    // R5: Q changes only when the double-rate clock rises
    p_q_on_dbl_rise_r5: assert property (@(posedge clk_osc) disable iff (hold)
        (q_o[0] != $past(q_o[0]) && !$past(hold)) |-> $rose(dbl_o));

    if (SYNC_STAGES == 2) begin : g_lat_chk
        // R9: in bypass the double-rate level is the inverse reference, three clocks late
        p_bypass_follow_r9: assert property (@(posedge clk_osc) disable iff (hold || !arm_done)
            $past(!loop_en) |-> (dbl_o == !$past(ref_cmp_o, 3)));
    end

endmodule

// File: tb/clkdist_top_tb_top.sv
`timescale 1ns/1ps
module clkdist_top_tb_top;

    localparam int NQ = 5;

    typedef struct {
        bit    valid;
        bit    oe;
        bit    dbl;
        bit    q;
        bit    qn;
        bit    half;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic oe_rst_n = 1'b0, loop_en = 1'b1, div_one = 1'b1, ref_pick = 1'b0;
    logic ref_a = 1'b1, ref_b = 1'b0;
    logic          ref_cmp_o, qn_o, qn_oe_o, dbl_o, dbl_oe_o, half_o, half_oe_o;
    logic [NQ-1:0] q_o, q_oe_o;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    bit h0 = 1'b1, h1 = 1'b1, h2 = 1'b1;
    bit mdbl = 1'b0, mq = 1'b0, mqn = 1'b0, mh = 1'b0, mpre = 1'b0;
    int drv_idx = 0;
    int c_q = 0, c_half = 0, c_dbl = 0, c_fall = 0;
    bit p_q = 1'b0, p_half = 1'b0, p_dbl = 1'b0, p_ref = 1'b1;

    always #10 clk = ~clk;

    clkdist_top #(.NUM_Q(NQ)) dut_i (
        .clk_osc(clk), .oe_rst_n(oe_rst_n), .loop_en(loop_en), .div_one(div_one),
        .ref_pick(ref_pick), .ref_a(ref_a), .ref_b(ref_b), .ref_cmp_o(ref_cmp_o),
        .q_o(q_o), .q_oe_o(q_oe_o), .qn_o(qn_o), .qn_oe_o(qn_oe_o),
        .dbl_o(dbl_o), .dbl_oe_o(dbl_oe_o), .half_o(half_o), .half_oe_o(half_oe_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        c_q = 0; c_half = 0; c_dbl = 0; c_fall = 0;
        p_q = q_o[0]; p_half = half_o; p_dbl = dbl_o;
    endtask

    // one clock of stimulus plus the expected state after the next edge
    task automatic run(input int n, input bit oe_n, input bit le, input bit d1,
                       input bit pk, input int hp, input bit lvl);
        for (int i = 0; i < n; i++) begin
            bit sel, nd;
            exp_t e;
            @(negedge clk);
            #1;
            if (q_o[0] && !p_q) c_q++;
            if (half_o && !p_half) c_half++;
            if (dbl_o && !p_dbl) c_dbl++;
            p_q = q_o[0]; p_half = half_o; p_dbl = dbl_o;
            sel = (hp == 0) ? lvl : (lvl ^ bit'((i / hp) % 2));
            oe_rst_n = oe_n; loop_en = le; div_one = d1; ref_pick = pk;
            if (pk) begin ref_b = sel; ref_a = bit'(i % 2); end
            else    begin ref_a = sel; ref_b = bit'(i % 2); end
            if (p_ref && !sel) c_fall++;
            p_ref = sel;
            #1;
            chk(ref_cmp_o == sel, "R1", "selected reference", ref_cmp_o, sel);
            chk(dbl_oe_o == oe_n && half_oe_o == oe_n && qn_oe_o == oe_n &&
                q_oe_o == {NQ{oe_n}}, "R6", "enables follow oe_rst_n at once",
                q_oe_o, {NQ{oe_n}});
            h2 = h1; h1 = h0; h0 = sel;
            if (!oe_n) begin
                mdbl = ~h2; mq = 0; mqn = 0; mh = 0; mpre = 0;
                e.tag = "R7";
            end else begin
                if (!le)     begin nd = ~h2; mpre = 0; e.tag = "R9"; end
                else if (d1) begin nd = ~mdbl; mpre = 0; e.tag = "R3"; end
                else         begin nd = mpre ? ~mdbl : mdbl; mpre = ~mpre; e.tag = "R4"; end
                if (nd && !mdbl) begin
                    if (!mq) mh = ~mh;
                    mqn = mq;
                    mq = ~mq;
                end
                mdbl = nd;
            end
            e.valid = (drv_idx >= 3);
            e.oe = oe_n; e.dbl = mdbl; e.q = mq; e.qn = mqn; e.half = mh;
            exp_q.push_back(e);
            drv_idx++;
        end
    endtask

    // scoreboard monitor: samples after each edge, away from it
    always begin
        exp_t e;
        @(posedge clk);
        #5;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk((q_o == '0) || (q_o == '1), "R2", "Q lanes in phase", q_o, {NQ{q_o[0]}});
            chk(q_o[0] == e.q, e.tag, "Q level", q_o[0], e.q);
            chk(qn_o == e.qn, "R7", "inverted Q level", qn_o, e.qn);
            chk(half_o == e.half, e.tag, "half-rate level", half_o, e.half);
            if (e.valid)
                chk(dbl_o == e.dbl, (e.tag == "R7") ? "R8" : e.tag, "double-rate level",
                    dbl_o, e.dbl);
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        run(8, 0, 1, 1, 0, 0, 1);
        #5;
        chk(q_oe_o == '0 && !dbl_oe_o, "R6", "reset enables low", q_oe_o, 0);
        chk(q_o == '0 && !qn_o && !half_o, "R7", "reset levels low", q_o, 0);
        // loop divide-by-1 rates
        clear_counts();
        run(64, 1, 1, 1, 0, 0, 1);
        run(1, 0, 1, 1, 0, 0, 1);
        chk(c_dbl == 32, "R3", "double-rate rises", c_dbl, 32);
        chk(c_q == 16, "R3", "Q rises", c_q, 16);
        chk(c_half == 8, "R5", "half-rate rises div1", c_half, 8);
        run(3, 0, 1, 0, 0, 0, 1);
        #5;
        chk(q_o == '0 && !half_o && !qn_o, "R7", "cleared by hold", q_o, 0);
        // loop divide-by-2 rates
        clear_counts();
        run(64, 1, 1, 0, 0, 0, 1);
        run(1, 1, 1, 0, 0, 0, 1);
        chk(c_dbl == 16, "R4", "double-rate rises", c_dbl, 16);
        chk(c_q == 8, "R4", "Q rises", c_q, 8);
        chk(c_half == 4, "R5", "half-rate rises div2", c_half, 4);
        // other reference while looping; unselected input toggles
        run(20, 1, 1, 0, 1, 0, 0);
        // bypass: hold, then long constant-high reference
        run(4, 0, 0, 1, 1, 0, 1);
        clear_counts();
        run(10, 1, 0, 1, 1, 0, 1);
        chk(c_q == 0 && q_o == '0 && !half_o && !qn_o, "R8", "bypass stays low before a fall",
            c_q, 0);
        run(60, 1, 0, 1, 1, 3, 1);
        run(6, 1, 0, 1, 1, 0, 1);
        chk(c_fall == 10, "R9", "reference falls driven", c_fall, 10);
        chk(c_q == 5, "R9", "Q rises per two falls", c_q, 5);
        chk(c_half == 3, "R9", "half-rate rises in bypass", c_half, 3);
        // bypass on the other input with a faster pattern, then back to loop without hold
        run(40, 1, 0, 0, 0, 2, 0);
        run(30, 1, 1, 1, 0, 0, 0);
        run(3, 1, 1, 1, 0, 0, 0);
        @(posedge clk);
        #6;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule